// File: doc/BRIEF.md
# Streaming Move-Instruction Decoder

This block decodes the data-move instruction group of a legacy 16/32-bit variable-length CISC instruction set. Bytes arrive one per cycle over a valid/ready handshake. The decoder tracks an operand-size override prefix and a two-byte escape, then identifies the move form. It collects the ModR/M, SIB, displacement and immediate bytes that the form calls for. When the last byte of an instruction has been taken, it presents one decoded record. The record gives the form, the direction, the operand size, the register and addressing fields, the displacement or absolute offset, and the immediate. If the encoding is not allowed, the record carries an illegal flag instead.

A front end feeds the block with byte-aligned instruction bytes. The block does not compute effective addresses and does not carry out the move. The `mode32` input gives the default operand size and the `addr32` input gives the address size. Both must stay constant while an instruction is being decoded.

Top module: `mov_stream_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. The record is presented with `out_valid` high for exactly one cycle, which is the cycle after the final byte is taken. No record appears while an instruction is still incomplete. `in_ready` is 0 only during the record cycle. Cycles with `in_valid` low change nothing.
- R3: Opcodes 0x88 to 0x8B produce form 0, register/memory, and take one ModR/M byte. Opcode bit 1 gives the direction and opcode bit 0 selects full operand size over byte size. The form codes are: 0 register/memory, 1 immediate-to-register, 2 immediate-to-r/m, 3 accumulator/absolute offset, 4 segment, 5 control, 6 debug, 7 test. `out_dir` is 1 when the register named by the reg field, by the opcode, or the accumulator is the destination.
- R4: `out_size` is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit. The full operand size is 32 when `mode32` XOR prefix-seen is 1, and 16 otherwise. Prefix-seen is set by one or more 0x66 bytes placed ahead of the opcode. The prefix is forgotten after every record.
- R5: Opcodes 0xB0 to 0xBF produce form 1 with `out_reg` equal to opcode bits 2:0. Opcodes 0xB0 to 0xB7 take a 1-byte immediate. Opcodes 0xB8 to 0xBF take a 2-byte or 4-byte immediate, following the operand size. Immediates are assembled little-endian and zero-extended into `out_imm`.
- R6: Opcodes 0xC6 and 0xC7 produce form 2 and take a ModR/M byte, any displacement, and then an immediate. The immediate is 1 byte for 0xC6 and 2 or 4 bytes for 0xC7. A ModR/M reg field other than 0 gives an illegal record right after the ModR/M byte.
- R7: Opcodes 0xA0 to 0xA3 produce form 4's neighbour form 3, with no ModR/M byte. The record holds a 2-byte absolute offset when `addr32` is 0 and a 4-byte one when it is 1, placed little-endian in `out_disp`. 0xA0 and 0xA1 have direction 1 and 0xA2 and 0xA3 have direction 0. The even opcode of each pair is the byte form.
- R8: The displacement length follows ModR/M. For 16-bit addresses: mod 00 with rm 110 takes 2 bytes, mod 01 takes 1, mod 10 takes 2. For 32-bit addresses: mod 01 takes 1 and mod 10 takes 4. With mod 00, rm 101 takes 4, and so does rm 100 with SIB base 101. With 32-bit addresses, rm 100 and mod not 11 fetch one SIB byte first, and `out_has_sib` is then set. mod 11 takes nothing.
- R9: Opcode 0x8C (direction 0) and opcode 0x8E (direction 1) produce form 4 at the full operand size. `out_upper_undef` is 1 only for 0x8C at 32-bit size with mod 11.
- R10: An 0x8E whose reg field is 1 gives an illegal record right after the ModR/M byte.
- R11: An 0x0F escape followed by 0x20/0x22 gives form 5, 0x21/0x23 gives form 6, and 0x24/0x26 gives form 7. The lower second byte of each pair has direction 0. These forms take one ModR/M byte and no displacement, and their size is 32. The allowed register numbers are 0, 2, 3 and 4 for form 5, then 0 to 3, 6 and 7 for form 6, then 3 to 7 for form 7. Any other number gives an illegal record.
- R12: An opcode, or an escaped second byte, outside the group gives an illegal record in the cycle after that byte. The decoder then starts the next instruction at the prefix stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | Default operand size is 32 bits |
| addr32 | input | 1 | 32-bit addressing |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder takes a byte this cycle |
| out_valid | output | 1 | Decoded record strobe |
| out_illegal | output | 1 | Encoding rejected |
| out_form | output | 3 | Move form code |
| out_dir | output | 1 | Reg-side operand is the destination |
| out_size | output | 2 | Operand size code |
| out_reg | output | 3 | Reg field or register from the opcode |
| out_mod | output | 2 | ModR/M mod field |
| out_rm | output | 3 | ModR/M rm field |
| out_has_sib | output | 1 | A SIB byte was collected |
| out_sib | output | 8 | SIB byte |
| out_disp | output | 32 | Displacement or absolute offset |
| out_imm | output | 32 | Immediate |
| out_upper_undef | output | 1 | Upper 16 bits of the destination are undefined |

## Verification
A wrong byte count in the collection state shows up as a record strobe that comes one or more cycles early or late against the final byte. The reference model compares the strobe every cycle, so the error is caught on the very instruction that has it. Wrong latched prefix or form state shows up as a bad size, form or direction field in that same record. Prefix state that leaks between instructions shows up on the next record. A wrong legality decision shows up as an illegal flag on the record that follows the ModR/M byte or the opcode.

// File: rtl/mvd_pkg.sv
package mvd_pkg;

   localparam logic [7:0] OPSIZE_PREFIX = 8'h66;
   localparam logic [7:0] ESCAPE_BYTE   = 8'h0F;

   typedef enum logic [2:0] {
      FORM_RM, FORM_IMM_REG, FORM_IMM_RM, FORM_ACC,
      FORM_SEG, FORM_CTRL, FORM_DEBUG, FORM_TEST
   } mvd_form_e;

   typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2} mvd_size_e;

   typedef enum logic [2:0] {
      ST_PFX, ST_ESC, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
   } mvd_state_e;

   typedef struct packed {
      logic      legal;
      mvd_form_e form;
      logic      dir;
      mvd_size_e size;
      logic      modrm;
      logic [2:0] reg_no;
      logic [2:0] imm_len;
      logic [2:0] offs_len;
      logic      seg_store;
   } mvd_op_t;

endpackage

// File: rtl/mvd_opclass.sv
module mvd_opclass
   import mvd_pkg::*;
(
   input  logic [7:0] op,
   input  logic       escaped,
   input  logic       op32,
   input  logic       addr32,
   output mvd_op_t    info
);
   mvd_size_e  full_sz;
   logic [2:0] word_len;
   logic [2:0] addr_len;

   assign full_sz  = op32 ? SZ_32 : SZ_16;
   assign word_len = op32 ? 3'd4 : 3'd2;
   assign addr_len = addr32 ? 3'd4 : 3'd2;

   always_comb begin
      info = '0;
      if (escaped) begin
         info.size  = SZ_32;
         info.modrm = 1'b1;
         info.legal = 1'b1;
         info.dir   = op[1];
         case (op)
            8'h20, 8'h22: info.form = FORM_CTRL;
            8'h21, 8'h23: info.form = FORM_DEBUG;
            8'h24, 8'h26: info.form = FORM_TEST;
            default:      info.legal = 1'b0;
         endcase
      end else begin
         casez (op)
            8'b1000_10??: begin
               info.legal = 1'b1;
               info.form  = FORM_RM;
               info.modrm = 1'b1;
               info.dir   = op[1];
               info.size  = op[0] ? full_sz : SZ_8;
            end
            8'b1011_????: begin
               info.legal   = 1'b1;
               info.form    = FORM_IMM_REG;
               info.dir     = 1'b1;
               info.reg_no  = op[2:0];
               info.size    = op[3] ? full_sz : SZ_8;
               info.imm_len = op[3] ? word_len : 3'd1;
            end
            8'b1100_011?: begin
               info.legal   = 1'b1;
               info.form    = FORM_IMM_RM;
               info.modrm   = 1'b1;
               info.size    = op[0] ? full_sz : SZ_8;
               info.imm_len = op[0] ? word_len : 3'd1;
            end
            8'b1010_00??: begin
               info.legal    = 1'b1;
               info.form     = FORM_ACC;
               info.dir      = ~op[1];
               info.size     = op[0] ? full_sz : SZ_8;
               info.offs_len = addr_len;
            end
            8'h8C, 8'h8E: begin
               info.legal     = 1'b1;
               info.form      = FORM_SEG;
               info.modrm     = 1'b1;
               info.dir       = op[1];
               info.size      = full_sz;
               info.seg_store = ~op[1];
            end
            default: info.legal = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/mvd_addr_len.sv
module mvd_addr_len (
   input  logic [1:0] md,
   input  logic [2:0] rm,
   input  logic [2:0] sib_base,
   input  logic       addr32,
   output logic       has_sib,
   output logic [2:0] disp_len
);
   always_comb begin
      has_sib  = 1'b0;
      disp_len = 3'd0;
      if (md != 2'b11) begin
         if (addr32) begin
            has_sib = (rm == 3'b100);
            case (md)
               2'b00:   disp_len = (rm == 3'b101 || (rm == 3'b100 && sib_base == 3'b101)) ? 3'd4 : 3'd0;
               2'b01:   disp_len = 3'd1;
               default: disp_len = 3'd4;
            endcase
         end else begin
            case (md)
               2'b00:   disp_len = (rm == 3'b110) ? 3'd2 : 3'd0;
               2'b01:   disp_len = 3'd1;
               default: disp_len = 3'd2;
            endcase
         end
      end
   end
endmodule

// File: rtl/mvd_sreg_check.sv
module mvd_sreg_check
   import mvd_pkg::*;
#(
   parameter bit ALLOW_TEST_REGS = 1'b1
) (
   input  mvd_form_e  form,
   input  logic [2:0] reg_no,
   output logic       ok
);
   logic test_ok;

   generate
      if (ALLOW_TEST_REGS) begin : g_test_on
         assign test_ok = (reg_no >= 3'd3);
      end else begin : g_test_off
         assign test_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      case (form)
         FORM_CTRL:  ok = (reg_no == 3'd0) || (reg_no == 3'd2) || (reg_no == 3'd3) || (reg_no == 3'd4);
         FORM_DEBUG: ok = (reg_no != 3'd4) && (reg_no != 3'd5);
         FORM_TEST:  ok = test_ok;
         default:    ok = 1'b1;
      endcase
   end
endmodule

// File: rtl/mov_stream_decoder.sv
module mov_stream_decoder
   import mvd_pkg::*;
#(
   parameter int unsigned FIELD_BYTES     = 4,
   parameter bit          ALLOW_TEST_REGS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mode32,
   input  logic        addr32,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   output logic        in_ready,
   output logic        out_valid,
   output logic        out_illegal,
   output logic [2:0]  out_form,
   output logic        out_dir,
   output logic [1:0]  out_size,
   output logic [2:0]  out_reg,
   output logic [1:0]  out_mod,
   output logic [2:0]  out_rm,
   output logic        out_has_sib,
   output logic [7:0]  out_sib,
   output logic [31:0] out_disp,
   output logic [31:0] out_imm,
   output logic        out_upper_undef
);
   localparam int unsigned FIELD_W = 8 * FIELD_BYTES;

   initial begin : chk_params
      assert (FIELD_BYTES == 4) else $fatal(1, "FIELD_BYTES must be 4");
   end

   mvd_state_e state_q, nxt_state;
   mvd_form_e  form_q;
   mvd_size_e  size_q;
   logic       pfx_q, dir_q, illegal_q, valid_q, undef_q, has_sib_q, seg_store_q;
   logic [2:0] reg_q, rm_q, imm_len_q, len_q, nxt_len, cnt_q;
   logic [1:0] mod_q;
   logic [7:0] sib_q;
   logic [FIELD_W-1:0] disp_q, imm_q;

   logic    accept, emit, bad, last, opc_load, special, modrm_bad, sreg_ok;
   logic    a_has_sib;
   logic [2:0] a_len;
   logic [1:0] a_md;
   logic [2:0] a_rm;
   mvd_op_t info;

   assign in_ready = ~valid_q;
   assign accept   = in_valid & in_ready;
   assign last     = (cnt_q + 3'd1 == len_q);
   assign special  = (form_q == FORM_CTRL) || (form_q == FORM_DEBUG) || (form_q == FORM_TEST);

   mvd_opclass u_opclass (
      .op      (in_byte),
      .escaped (state_q == ST_ESC),
      .op32    (mode32 ^ pfx_q),
      .addr32  (addr32),
      .info    (info)
   );

   assign a_md = (state_q == ST_SIB) ? mod_q : in_byte[7:6];
   assign a_rm = (state_q == ST_SIB) ? rm_q  : in_byte[2:0];

   mvd_addr_len u_addr_len (
      .md       (a_md),
      .rm       (a_rm),
      .sib_base (in_byte[2:0]),
      .addr32   (addr32),
      .has_sib  (a_has_sib),
      .disp_len (a_len)
   );

   mvd_sreg_check #(.ALLOW_TEST_REGS(ALLOW_TEST_REGS)) u_sreg_check (
      .form   (form_q),
      .reg_no (in_byte[5:3]),
      .ok     (sreg_ok)
   );

   assign modrm_bad = ((form_q == FORM_IMM_RM) && (in_byte[5:3] != 3'd0))
                    || ((form_q == FORM_SEG) && dir_q && (in_byte[5:3] == 3'd1))
                    || (special && !sreg_ok);

   assign opc_load = accept && info.legal
                   && ((state_q == ST_ESC)
                       || ((state_q == ST_PFX) && (in_byte != OPSIZE_PREFIX) && (in_byte != ESCAPE_BYTE)));

   // next-state selection
   always_comb begin
      nxt_state = state_q;
      nxt_len   = len_q;
      emit      = 1'b0;
      bad       = 1'b0;
      if (accept) begin
         case (state_q)
            ST_PFX, ST_ESC: begin
               if (state_q == ST_PFX && in_byte == OPSIZE_PREFIX) begin
                  nxt_state = ST_PFX;
               end else if (state_q == ST_PFX && in_byte == ESCAPE_BYTE) begin
                  nxt_state = ST_ESC;
               end else if (!info.legal) begin
                  emit = 1'b1;
                  bad  = 1'b1;
               end else if (info.modrm) begin
                  nxt_state = ST_MODRM;
               end else if (info.form == FORM_ACC) begin
                  nxt_state = ST_DISP;
                  nxt_len   = info.offs_len;
               end else begin
                  nxt_state = ST_IMM;
                  nxt_len   = info.imm_len;
               end
            end
            ST_MODRM, ST_SIB: begin
               if (state_q == ST_MODRM && modrm_bad) begin
                  emit = 1'b1;
                  bad  = 1'b1;
               end else if (state_q == ST_MODRM && special) begin
                  emit = 1'b1;
               end else if (state_q == ST_MODRM && a_has_sib) begin
                  nxt_state = ST_SIB;
               end else if (a_len != 3'd0) begin
                  nxt_state = ST_DISP;
                  nxt_len   = a_len;
               end else if (imm_len_q != 3'd0) begin
                  nxt_state = ST_IMM;
                  nxt_len   = imm_len_q;
               end else begin
                  emit = 1'b1;
               end
            end
            ST_DISP: begin
               if (last) begin
                  if (imm_len_q != 3'd0) begin
                     nxt_state = ST_IMM;
                     nxt_len   = imm_len_q;
                  end else begin
                     emit = 1'b1;
                  end
               end
            end
            default: begin
               if (last) emit = 1'b1;
            end
         endcase
         if (emit) nxt_state = ST_PFX;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_PFX;
         pfx_q       <= 1'b0;
         valid_q     <= 1'b0;
         illegal_q   <= 1'b0;
         form_q      <= FORM_RM;
         size_q      <= SZ_8;
         dir_q       <= 1'b0;
         seg_store_q <= 1'b0;
         reg_q       <= '0;
         mod_q       <= '0;
         rm_q        <= '0;
         sib_q       <= '0;
         has_sib_q   <= 1'b0;
         undef_q     <= 1'b0;
         imm_len_q   <= '0;
         len_q       <= '0;
         cnt_q       <= '0;
         disp_q      <= '0;
         imm_q       <= '0;
      end else begin
         state_q <= nxt_state;
         len_q   <= nxt_len;
         valid_q <= emit;
         if (emit) begin
            illegal_q <= bad;
            pfx_q     <= 1'b0;
         end else if (accept && state_q == ST_PFX && in_byte == OPSIZE_PREFIX) begin
            pfx_q <= 1'b1;
         end
         if (opc_load) begin
            form_q      <= info.form;
            size_q      <= info.size;
            dir_q       <= info.dir;
            seg_store_q <= info.seg_store;
            reg_q       <= info.reg_no;
            imm_len_q   <= info.imm_len;
            mod_q       <= '0;
            rm_q        <= '0;
            sib_q       <= '0;
            has_sib_q   <= 1'b0;
            undef_q     <= 1'b0;
            disp_q      <= '0;
            imm_q       <= '0;
         end
         if (accept) begin
            case (state_q)
               ST_MODRM: begin
                  mod_q   <= in_byte[7:6];
                  reg_q   <= in_byte[5:3];
                  rm_q    <= in_byte[2:0];
                  undef_q <= seg_store_q && (size_q == SZ_32) && (in_byte[7:6] == 2'b11);
               end
               ST_SIB: begin
                  sib_q     <= in_byte;
                  has_sib_q <= 1'b1;
               end
               ST_DISP: begin
                  disp_q[{cnt_q[1:0], 3'b000} +: 8] <= in_byte;
                  cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
               end
               ST_IMM: begin
                  imm_q[{cnt_q[1:0], 3'b000} +: 8] <= in_byte;
                  cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
               end
               default: ;
            endcase
         end
      end
   end

   assign out_valid       = valid_q;
   assign out_illegal     = illegal_q;
   assign out_form        = form_q;
   assign out_dir         = dir_q;
   assign out_size        = size_q;
   assign out_reg         = reg_q;
   assign out_mod         = mod_q;
   assign out_rm          = rm_q;
   assign out_has_sib     = has_sib_q;
   assign out_sib         = sib_q;
   assign out_disp        = disp_q;
   assign out_imm         = imm_q;
   assign out_upper_undef = undef_q;

   AST_ONE_CYCLE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R2
   AST_RECORD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(accept)); // R2
   AST_SHORT_IMM_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !illegal_q && form_q == FORM_IMM_REG && size_q == SZ_8) |-> (imm_q[31:8] == 24'd0)); // R5
   AST_IMMRM_REG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !illegal_q && form_q == FORM_IMM_RM) |-> (reg_q == 3'd0)); // R6
   AST_UNDEF_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && undef_q) |-> (form_q == FORM_SEG && size_q == SZ_32 && !dir_q && mod_q == 2'b11)); // R9
   AST_CS_NEVER_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !illegal_q && form_q == FORM_SEG && dir_q) |-> (reg_q != 3'd1)); // R10
   AST_SPECIAL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !illegal_q && special) |-> (size_q == SZ_32 && disp_q == '0)); // R11
   AST_BACK_TO_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (state_q == ST_PFX && !pfx_q)); // R12
endmodule

// File: tb/mov_stream_decoder_test.sv
module mov_stream_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode32 = 1'b0, addr32 = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_ready, out_valid, out_illegal, out_dir, out_has_sib, out_upper_undef;
   logic [2:0]  out_form, out_reg, out_rm;
   logic [1:0]  out_size, out_mod;
   logic [7:0]  out_sib;
   logic [31:0] out_disp, out_imm;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mov_stream_decoder uut (
      .clk(clk), .rst_n(rst_n), .mode32(mode32), .addr32(addr32),
      .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_form(out_form),
      .out_dir(out_dir), .out_size(out_size), .out_reg(out_reg), .out_mod(out_mod),
      .out_rm(out_rm), .out_has_sib(out_has_sib), .out_sib(out_sib),
      .out_disp(out_disp), .out_imm(out_imm), .out_upper_undef(out_upper_undef)
   );

   typedef struct {
      bit ill; int form; bit dir; int size; int rg; int md; int rm;
      bit hs; int sib; logic [31:0] disp; logic [31:0] imm; bit undef;
   } rec_t;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic rec_t model(input logic [7:0] b[$], input bit m32, input bit a32);
      rec_t r;
      int i = 0;
      bit p = 0, o32, mr = 0, sp = 0;
      int wl, il = 0, dl = 0;
      logic [7:0] op, m;
      r.ill = 0; r.form = 0; r.dir = 0; r.size = 0; r.rg = 0; r.md = 0; r.rm = 0;
      r.hs = 0; r.sib = 0; r.disp = 0; r.imm = 0; r.undef = 0;
      while (b[i] == 8'h66) begin p = 1; i++; end
      o32 = m32 ^ p;
      wl = o32 ? 4 : 2;
      op = b[i]; i++;
      if (op == 8'h0F) begin
         op = b[i]; i++; sp = 1; mr = 1; r.size = 2;
         case (op)
            8'h20: begin r.form = 5; r.dir = 0; end
            8'h22: begin r.form = 5; r.dir = 1; end
            8'h21: begin r.form = 6; r.dir = 0; end
            8'h23: begin r.form = 6; r.dir = 1; end
            8'h24: begin r.form = 7; r.dir = 0; end
            8'h26: begin r.form = 7; r.dir = 1; end
            default: begin r.ill = 1; return r; end
         endcase
      end else if (op >= 8'h88 && op <= 8'h8B) begin
         r.form = 0; r.dir = op[1]; r.size = op[0] ? (o32 ? 2 : 1) : 0; mr = 1;
      end else if (op >= 8'hB0 && op <= 8'hBF) begin
         r.form = 1; r.dir = 1; r.rg = op % 8;
         if (op >= 8'hB8) begin r.size = o32 ? 2 : 1; il = wl; end
         else begin r.size = 0; il = 1; end
      end else if (op == 8'hC6 || op == 8'hC7) begin
         r.form = 2; mr = 1;
         if (op == 8'hC7) begin r.size = o32 ? 2 : 1; il = wl; end
         else begin r.size = 0; il = 1; end
      end else if (op >= 8'hA0 && op <= 8'hA3) begin
         r.form = 3; r.dir = (op < 8'hA2); r.size = op[0] ? (o32 ? 2 : 1) : 0;
         dl = a32 ? 4 : 2;
      end else if (op == 8'h8C || op == 8'h8E) begin
         r.form = 4; r.dir = (op == 8'h8E); r.size = o32 ? 2 : 1; mr = 1;
      end else begin
         r.ill = 1; return r;
      end
      if (mr) begin
         m = b[i]; i++;
         r.md = m / 64; r.rg = (m / 8) % 8; r.rm = m % 8;
         if (r.form == 2 && r.rg != 0) r.ill = 1;
         if (r.form == 4 && r.dir && r.rg == 1) r.ill = 1;
         if (r.form == 5 && !(r.rg inside {0, 2, 3, 4})) r.ill = 1;
         if (r.form == 6 && (r.rg == 4 || r.rg == 5)) r.ill = 1;
         if (r.form == 7 && r.rg < 3) r.ill = 1;
         if (r.ill) return r;
         if (r.form == 4 && !r.dir && o32 && r.md == 3) r.undef = 1;
         if (!sp && r.md != 3) begin
            if (a32) begin
               if (r.rm == 4) begin r.hs = 1; r.sib = b[i]; i++; end
               if (r.md == 1) dl = 1;
               else if (r.md == 2) dl = 4;
               else if (r.rm == 5 || (r.hs && r.sib % 8 == 5)) dl = 4;
            end else begin
               if (r.md == 1) dl = 1;
               else if (r.md == 2) dl = 2;
               else if (r.rm == 6) dl = 2;
            end
         end
      end
      for (int k = 0; k < dl; k++) r.disp = r.disp | (32'(b[i + k]) << (8 * k));
      i += dl;
      for (int k = 0; k < il; k++) r.imm = r.imm | (32'(b[i + k]) << (8 * k));
      return r;
   endfunction

   task automatic run(input logic [7:0] b[$], input bit m32, input bit a32,
                      input bit gap, input string req);
      rec_t e;
      e = model(b, m32, a32);
      mode32 = m32;
      addr32 = a32;
      for (int k = 0; k < b.size(); k++) begin
         if (gap && k > 0) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'h66;
            chk(!out_valid, "R2", "record during idle gap", 32'(out_valid), 0);
         end
         @(negedge clk);
         chk(!out_valid && in_ready, "R2", "mid-instruction strobe/ready",
             {30'd0, out_valid, in_ready}, 32'd1);
         in_valid = 1'b1;
         in_byte  = b[k];
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R2", "record strobe after last byte", 32'(out_valid), 1);
      chk(in_ready == 1'b0, "R2", "ready low in record cycle", 32'(in_ready), 0);
      chk(out_illegal == e.ill, req, "illegal flag", 32'(out_illegal), 32'(e.ill));
      if (!e.ill) begin
         chk(32'(out_form) == e.form, req, "form", 32'(out_form), e.form);
         chk(out_dir == e.dir, req, "dir", 32'(out_dir), 32'(e.dir));
         chk(32'(out_size) == e.size, req, "size", 32'(out_size), e.size);
         chk(32'(out_reg) == e.rg, req, "reg", 32'(out_reg), e.rg);
         chk(32'(out_mod) == e.md, req, "mod", 32'(out_mod), e.md);
         chk(32'(out_rm) == e.rm, req, "rm", 32'(out_rm), e.rm);
         chk(out_has_sib == e.hs, req, "has_sib", 32'(out_has_sib), 32'(e.hs));
         chk(32'(out_sib) == e.sib, req, "sib", 32'(out_sib), e.sib);
         chk(out_disp == e.disp, req, "disp", out_disp, e.disp);
         chk(out_imm == e.imm, req, "imm", out_imm, e.imm);
         chk(out_upper_undef == e.undef, req, "upper_undef", 32'(out_upper_undef), 32'(e.undef));
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 0);
      chk(in_ready == 1'b1, "R1", "ready in reset", 32'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R1", "idle after reset", {30'd0, out_valid, in_ready}, 1);

      run('{8'h88, 8'hC3}, 0, 0, 0, "R3");
      run('{8'h8B, 8'h45, 8'h08}, 1, 0, 0, "R3");
      run('{8'h66, 8'h89, 8'h06, 8'h34, 8'h12}, 1, 0, 0, "R4");
      run('{8'h66, 8'h66, 8'h8B, 8'hC1}, 0, 1, 1, "R4");
      run('{8'h8A, 8'h84, 8'h24, 8'h78, 8'h56, 8'h34, 8'h12}, 1, 1, 0, "R8");
      run('{8'h8B, 8'h04, 8'h25, 8'hEF, 8'hBE, 8'hAD, 8'hDE}, 1, 1, 0, "R8");
      run('{8'h8B, 8'h05, 8'h44, 8'h33, 8'h22, 8'h11}, 1, 1, 1, "R8");
      run('{8'h89, 8'h4C, 8'h24, 8'hF0}, 1, 1, 0, "R8");
      run('{8'h8B, 8'h00}, 0, 0, 0, "R8");
      run('{8'hB3, 8'h7F}, 0, 0, 0, "R5");
      run('{8'hB9, 8'h01, 8'h02, 8'h03, 8'h04}, 1, 0, 1, "R5");
      run('{8'h66, 8'hBA, 8'h34, 8'h12}, 1, 0, 0, "R5");
      run('{8'hC7, 8'h80, 8'h10, 8'h00, 8'hAA, 8'hBB}, 0, 0, 0, "R6");
      run('{8'hC6, 8'hC1, 8'h5A}, 0, 0, 0, "R6");
      run('{8'hC6, 8'h48}, 0, 0, 0, "R6");
      run('{8'hA1, 8'h00, 8'h10, 8'h00, 8'h00}, 1, 1, 0, "R7");
      run('{8'hA2, 8'h34, 8'h12}, 0, 0, 1, "R7");
      run('{8'h8C, 8'hD8}, 1, 0, 0, "R9");
      run('{8'h8C, 8'h1E, 8'h00, 8'h20}, 1, 0, 0, "R9");
      run('{8'h66, 8'h8C, 8'hD8}, 1, 0, 0, "R9");
      run('{8'h8E, 8'hD8}, 1, 0, 0, "R9");
      run('{8'h8E, 8'hC8}, 1, 0, 0, "R10");
      run('{8'h0F, 8'h20, 8'hC0}, 0, 0, 0, "R11");
      run('{8'h0F, 8'h22, 8'hD8}, 0, 0, 1, "R11");
      run('{8'h0F, 8'h20, 8'hC8}, 0, 0, 0, "R11");
      run('{8'h0F, 8'h21, 8'hF8}, 0, 0, 0, "R11");
      run('{8'h0F, 8'h23, 8'hE0}, 0, 0, 0, "R11");
      run('{8'h0F, 8'h24, 8'hD8}, 0, 0, 0, "R11");
      run('{8'h0F, 8'h26, 8'hD0}, 0, 0, 0, "R11");
      run('{8'h0F, 8'h20, 8'h05}, 1, 1, 0, "R11");
      run('{8'h90}, 0, 0, 0, "R12");
      run('{8'h0F, 8'h05}, 0, 0, 0, "R12");
      run('{8'h66, 8'h90}, 1, 0, 0, "R12");
      run('{8'h89, 8'hC0}, 1, 0, 0, "R12");

      @(negedge clk);
      chk(!out_valid && in_ready, "R2", "idle at end", {30'd0, out_valid, in_ready}, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule